// File: doc/BRIEF.md
# Maintenance Request Window Guard

This block sits beside the memory-mapped port that issues maintenance reads and writes. It compares every request address against a small set of programmable address windows. Each window holds a base, a mask and an enable bit. When a request falls inside an enabled window, the block reports a hit, the index of the matching window and the offset of the address within that window, all in the same cycle as the request.

A valid request that falls in no enabled window sets a sticky out-of-bounds flag. Reads and writes have separate flags. Software clears a flag by writing a one to it. A per-flag enable decides which flags drive the registered interrupt line. All registers are reached through a simple register port: a write takes effect on the next clock edge, and read data appears one cycle after the read strobe.

The register offsets are fixed:
- out-of-bounds status at 0x10080
- interrupt enable at 0x10084
- window n base at 0x10100 + 0x10·n
- window n mask at 0x10104 + 0x10·n

Top module: `maint_win_guard`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: The window enable is bit 2 of the mask register. A window whose enable bit is 0 never matches, whatever its base and mask hold.
- R3: An enabled window matches when (addr & mask) equals (base & mask). Bits [2:0] of both base and mask are taken as zero, so address bits [2:0] never affect a match.
- R4: When more than one enabled window matches, the lowest-numbered window is reported on `res_win`.
- R5: On a hit, `res_offset` equals addr & ~mask of the winning window, in the same cycle as the request. `res_hit` is 0 whenever `req_valid` is 0.
- R6: A valid request that misses every enabled window sets a status bit on the next clock edge. A write miss sets bit 1 and a read miss sets bit 0. An address presented with `req_valid` at 0 sets nothing.
- R7: A status bit stays set until software writes a 1 to it at 0x10080. Writing 0 to a bit leaves it unchanged.
- R8: If a miss sets a status bit in the same cycle that a write-one-to-clear targets that bit, the bit ends up set.
- R9: `irq` is a register. Its value equals the OR of (status[1:0] & enable[1:0]) as it stood one cycle earlier.
- R10: In the enable register, bits 6:4 and 1:0 are read/write, and bits 3:2 and 31:7 read 0. Base bits [2:0] read 0, and mask bits [1:0] read 0.
- R11: `csr_rdata` presents the addressed register in the cycle after `csr_rd` is high. An unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | 17 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, one cycle after the read strobe |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_addr | input | 32 | Request address |
| res_hit | output | 1 | The request matched an enabled window |
| res_win | output | 1 | Index of the matching window |
| res_offset | output | 32 | Offset of the address inside the window |
| irq | output | 1 | Registered interrupt |

## Verification
A stored base, mask or enable bit that is wrong shows up in the same cycle as the next request that exercises it. It appears as a wrong hit, a wrong window index or a wrong offset. A lost or stuck status bit shows on the next status read, one cycle after the read strobe, and on `irq` one edge after the status change. The tests therefore set up overlapping windows, a disabled window, addresses that differ only in their low three bits, and a set and a clear that land in the same cycle. Each of these produces a distinct value at the ports.

// File: rtl/mwg_pkg.sv
package mwg_pkg;
  // fixed register offsets, byte addressed
  localparam logic [31:0] OFS_STATUS   = 32'h0001_0080;
  localparam logic [31:0] OFS_IRQ_EN   = 32'h0001_0084;
  localparam logic [31:0] OFS_WIN0     = 32'h0001_0100;
  localparam logic [31:0] WIN_STRIDE   = 32'h0000_0010;
  localparam logic [31:0] MASK_DELTA   = 32'h0000_0004;
  localparam int unsigned LOW_ZERO     = 3;  // base/mask low bits taken as zero
  localparam int unsigned EN_BIT       = 2;  // window enable inside mask register

  typedef struct packed {
    logic wr_oob;
    logic rd_oob;
  } oob_t;
endpackage

// File: rtl/mwg_win_regs.sv
module mwg_win_regs
  import mwg_pkg::*;
#(
  parameter int unsigned IDX    = 0,
  parameter int unsigned AW     = 32,
  parameter int unsigned CSR_AW = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [AW-1:0]     csr_wdata,
  output logic [AW-1:0]     base,
  output logic [AW-1:0]     mask,
  output logic              en,
  output logic              rd_sel,
  output logic [AW-1:0]     rd_data
);
  localparam logic [31:0] BASE_OFS = OFS_WIN0 + IDX * WIN_STRIDE;
  localparam logic [31:0] MASK_OFS = BASE_OFS + MASK_DELTA;

  logic [AW-1:LOW_ZERO] base_q, mask_q;
  logic                 en_q;
  logic                 sel_base, sel_mask;

  assign sel_base = (csr_addr == CSR_AW'(BASE_OFS));
  assign sel_mask = (csr_addr == CSR_AW'(MASK_OFS));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
    end else if (csr_wr) begin
      if (sel_base) base_q <= csr_wdata[AW-1:LOW_ZERO];
      if (sel_mask) begin
        mask_q <= csr_wdata[AW-1:LOW_ZERO];
        en_q   <= csr_wdata[EN_BIT];
      end
    end
  end

  assign base   = {base_q, {LOW_ZERO{1'b0}}};
  assign mask   = {mask_q, {LOW_ZERO{1'b0}}};
  assign en     = en_q;
  assign rd_sel = sel_base | sel_mask;

  always_comb begin
    rd_data = '0;
    if (sel_base) rd_data = base;
    if (sel_mask) begin
      rd_data         = mask;
      rd_data[EN_BIT] = en_q;
    end
  end
endmodule

// File: rtl/mwg_win_match.sv
module mwg_win_match #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  input  logic          en,
  output logic          match,
  output logic [AW-1:0] offset
);
  assign match  = en && ((addr & mask) == (base & mask));
  assign offset = addr & ~mask;
endmodule

// File: rtl/mwg_oob_status.sv
module mwg_oob_status
  import mwg_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned CSR_AW = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [DW-1:0]     csr_wdata,
  input  logic              ev_rd_miss,
  input  logic              ev_wr_miss,
  output oob_t              oob_q,
  output logic [1:0]        ien_lo,
  output logic              irq,
  output logic              rd_sel,
  output logic [DW-1:0]     rd_data
);
  logic       sel_sts, sel_ien;
  logic [2:0] ien_hi_q;   // bits 6:4, plain storage
  logic [1:0] ien_lo_q;   // bits 1:0, interrupt gates
  oob_t       set_v, clr_v, oob_n;
  logic       irq_q;

  assign sel_sts = (csr_addr == CSR_AW'(OFS_STATUS));
  assign sel_ien = (csr_addr == CSR_AW'(OFS_IRQ_EN));

  always_comb begin
    set_v.wr_oob = ev_wr_miss;
    set_v.rd_oob = ev_rd_miss;
    clr_v        = (csr_wr && sel_sts) ? oob_t'(csr_wdata[1:0]) : oob_t'(2'b00);
    oob_n        = (oob_q & ~clr_v) | set_v;   // set beats clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oob_q    <= '0;
      ien_hi_q <= '0;
      ien_lo_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      oob_q <= oob_n;
      if (csr_wr && sel_ien) begin
        ien_hi_q <= csr_wdata[6:4];
        ien_lo_q <= csr_wdata[1:0];
      end
      irq_q <= |(oob_q & ien_lo_q);
    end
  end

  assign ien_lo = ien_lo_q;
  assign irq    = irq_q;
  assign rd_sel = sel_sts | sel_ien;

  always_comb begin
    rd_data = '0;
    if (sel_sts) rd_data[1:0] = oob_q;
    if (sel_ien) begin
      rd_data[6:4] = ien_hi_q;
      rd_data[1:0] = ien_lo_q;
    end
  end
endmodule

// File: rtl/maint_win_guard.sv
module maint_win_guard
  import mwg_pkg::*;
#(
  parameter int unsigned NUM_WIN = 2,
  parameter int unsigned AW      = 32,
  parameter int unsigned CSR_AW  = 17,
  localparam int unsigned WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [AW-1:0]     csr_wdata,
  output logic [AW-1:0]     csr_rdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  output logic              res_hit,
  output logic [WIN_IW-1:0] res_win,
  output logic [AW-1:0]     res_offset,
  output logic              irq
);
  logic [AW-1:0]      w_base [NUM_WIN];
  logic [AW-1:0]      w_mask [NUM_WIN];
  logic [AW-1:0]      w_off  [NUM_WIN];
  logic [AW-1:0]      w_rd   [NUM_WIN];
  logic [NUM_WIN-1:0] win_en, w_match, w_sel;

  genvar g;
  generate
    for (g = 0; g < NUM_WIN; g++) begin : g_win
      mwg_win_regs #(.IDX(g), .AW(AW), .CSR_AW(CSR_AW)) u_regs (
        .clk, .rst, .csr_wr, .csr_addr, .csr_wdata,
        .base(w_base[g]), .mask(w_mask[g]), .en(win_en[g]),
        .rd_sel(w_sel[g]), .rd_data(w_rd[g])
      );
      mwg_win_match #(.AW(AW)) u_match (
        .addr(req_addr), .base(w_base[g]), .mask(w_mask[g]), .en(win_en[g]),
        .match(w_match[g]), .offset(w_off[g])
      );
    end
  endgenerate

  // lowest index wins
  logic              any_hit;
  logic [WIN_IW-1:0] pick;
  logic [AW-1:0]     pick_off;
  always_comb begin
    pick     = '0;
    pick_off = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (w_match[i]) begin
        pick     = WIN_IW'(i);
        pick_off = w_off[i];
      end
    end
  end
  assign any_hit    = |w_match;
  assign res_hit    = req_valid && any_hit;
  assign res_win    = res_hit ? pick : '0;
  assign res_offset = res_hit ? pick_off : '0;

  oob_t          oob_q;
  logic [1:0]    ien_lo;
  logic          s_sel;
  logic [AW-1:0] s_rd;
  mwg_oob_status #(.DW(AW), .CSR_AW(CSR_AW)) u_sts (
    .clk, .rst, .csr_wr, .csr_addr, .csr_wdata,
    .ev_rd_miss(req_valid && !req_write && !any_hit),
    .ev_wr_miss(req_valid &&  req_write && !any_hit),
    .oob_q, .ien_lo, .irq, .rd_sel(s_sel), .rd_data(s_rd)
  );

  // read mux: sub-blocks return zero when unselected
  logic [AW-1:0] rd_or;
  always_comb begin
    rd_or = s_sel ? s_rd : '0;
    for (int i = 0; i < NUM_WIN; i++)
      if (w_sel[i]) rd_or = rd_or | w_rd[i];
  end

  logic [AW-1:0] rdata_q;
  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (csr_rd) rdata_q <= rd_or;
  end
  assign csr_rdata = rdata_q;
endmodule

// File: rtl/maint_win_guard_chk.sv
module maint_win_guard_chk #(
  parameter int unsigned NUM_WIN = 2,
  parameter int unsigned AW      = 32,
  parameter int unsigned CSR_AW  = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              csr_wr,
  input logic [CSR_AW-1:0] csr_addr,
  input logic [AW-1:0]     csr_wdata,
  input logic              req_valid,
  input logic              req_write,
  input logic              res_hit,
  input logic              irq,
  input logic [1:0]        oob_bits,
  input logic [1:0]        ien_bits,
  input logic [NUM_WIN-1:0] win_en
);
  logic sts_wr;
  assign sts_wr = csr_wr && (csr_addr == CSR_AW'(32'h0001_0080));

  p_hit_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !res_hit);
  p_disabled_never_hits_r2: assert property (@(posedge clk) disable iff (rst)
    (win_en == '0) |-> !res_hit);
  p_wr_miss_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !res_hit) |=> oob_bits[1]);
  p_rd_miss_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !res_hit) |=> oob_bits[0]);
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (oob_bits[1] && !(sts_wr && csr_wdata[1])) |=> oob_bits[1]);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && csr_wdata[0] && !(req_valid && !req_write && !res_hit)) |=> !oob_bits[0]);
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == $past(|(oob_bits & ien_bits))));
endmodule

bind maint_win_guard maint_win_guard_chk #(.NUM_WIN(NUM_WIN), .AW(AW), .CSR_AW(CSR_AW)) u_chk (
  .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
  .req_valid(req_valid), .req_write(req_write), .res_hit(res_hit), .irq(irq),
  .oob_bits(oob_q), .ien_bits(ien_lo), .win_en(win_en)
);

// File: tb/test_maint_win_guard.sv
module test_maint_win_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [16:0] A_STS = 17'h10080, A_IEN = 17'h10084,
                          A_B0 = 17'h10100, A_M0 = 17'h10104,
                          A_B1 = 17'h10110, A_M1 = 17'h10114;

  logic        clk = 1'b0, rst = 1'b1;
  logic        csr_wr = 0, csr_rd = 0;
  logic [16:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic        req_valid = 0, req_write = 0;
  logic [31:0] req_addr = '0, res_offset;
  logic        res_hit, irq;
  logic [0:0]  res_win;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;

  maint_win_guard i_maint_win_guard (
    .clk, .rst, .csr_wr, .csr_rd, .csr_addr, .csr_wdata, .csr_rdata,
    .req_valid, .req_write, .req_addr, .res_hit, .res_win, .res_offset, .irq
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: read data is due the cycle after the strobe (R11)
  always @(posedge clk) rd_seen <= csr_rd;
  always @(negedge clk) if (rd_seen) begin
    if (exp_q.size() == 0) check("R11 unexpected read", 32'h1, 32'h0);
    else check(tag_q.pop_front(), csr_rdata, exp_q.pop_front());
  end

  task automatic csr_write(input logic [16:0] a, input logic [31:0] d);
    @(negedge clk); csr_wr = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic csr_read(input logic [16:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); csr_rd = 1; csr_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); csr_rd = 0;
  endtask

  task automatic request(input logic v, input logic wr, input logic [31:0] a,
                         input logic eh, input logic ew, input logic [31:0] eo, input string tag);
    @(negedge clk); req_valid = v; req_write = wr; req_addr = a;
    #1;
    check({tag, " hit"}, {31'b0, res_hit}, {31'b0, eh});
    check({tag, " win"}, {31'b0, res_win}, {31'b0, ew});
    check({tag, " offset"}, res_offset, eo);
    @(negedge clk); req_valid = 0;
  endtask

  task automatic irq_after(input logic e, input string tag);
    @(negedge clk); @(negedge clk);
    check(tag, {31'b0, irq}, {31'b0, e});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    csr_read(A_STS, 32'h0, "R1 status");
    csr_read(A_IEN, 32'h0, "R1 irq enable");
    csr_read(A_B0, 32'h0, "R1 base0");
    csr_read(A_M0, 32'h0, "R1 mask0");
    csr_read(A_B1, 32'h0, "R1 base1");
    csr_read(A_M1, 32'h0, "R1 mask1");
    csr_read(17'h10088, 32'h0, "R11 unmapped");
    // R2 windows disabled -> read miss; R6 read miss sets bit 0
    request(1, 0, 32'h0000_1234, 0, 0, 0, "R2 disabled");
    csr_read(A_STS, 32'h1, "R6 read miss");
    // R7 write 0 keeps, write 1 clears
    csr_write(A_STS, 32'h0);
    csr_read(A_STS, 32'h1, "R7 zero write");
    csr_write(A_STS, 32'h1);
    csr_read(A_STS, 32'h0, "R7 clear");
    // R6 invalid request sets nothing
    request(0, 1, 32'hDEAD_0000, 0, 0, 0, "R5 idle no hit");
    csr_read(A_STS, 32'h0, "R6 no valid");
    // R10 register fields
    csr_write(A_B0, 32'h0000_1007);
    csr_write(A_M0, 32'hFFFF_F007);
    csr_write(A_B1, 32'h0000_0003);
    csr_write(A_M1, 32'hFFFF_0004);
    csr_read(A_B0, 32'h0000_1000, "R10 base0 low bits");
    csr_read(A_M0, 32'hFFFF_F004, "R10 mask0 low bits");
    csr_read(A_B1, 32'h0, "R10 base1");
    csr_read(A_M1, 32'hFFFF_0004, "R10 mask1");
    // R3/R4/R5 matching
    request(1, 1, 32'h0000_1234, 1, 0, 32'h234, "R4 overlap win0");
    request(1, 0, 32'h0000_2345, 1, 1, 32'h2345, "R5 win1 offset");
    request(1, 0, 32'h0000_1007, 1, 0, 32'h7, "R3 low bits");
    request(1, 1, 32'h0001_0000, 0, 0, 0, "R3 write miss");
    csr_read(A_STS, 32'h2, "R6 write miss");
    request(1, 0, 32'hFFFF_1238, 0, 0, 0, "R3 read miss");
    csr_read(A_STS, 32'h3, "R6 both");
    // R2 disable window 0: falls to window 1
    csr_write(A_M0, 32'hFFFF_F000);
    request(1, 1, 32'h0000_1234, 1, 1, 32'h1234, "R2 win0 off");
    // R9/R10 interrupt
    check("R9 irq gated", {31'b0, irq}, 32'h0);
    csr_write(A_IEN, 32'hFFFF_FFFF);
    csr_read(A_IEN, 32'h73, "R10 enable fields");
    irq_after(1, "R9 irq on");
    csr_write(A_STS, 32'h1);
    irq_after(1, "R9 irq from write bit");
    csr_write(A_IEN, 32'h1);
    irq_after(0, "R9 irq masked");
    csr_write(A_STS, 32'h2);
    csr_read(A_STS, 32'h0, "R7 cleared");
    // R8 set wins over clear
    csr_write(A_IEN, 32'h3);
    @(negedge clk);
    csr_wr = 1; csr_addr = A_STS; csr_wdata = 32'h2;
    req_valid = 1; req_write = 1; req_addr = 32'h0002_0000;
    @(negedge clk);
    csr_wr = 0; req_valid = 0;
    csr_read(A_STS, 32'h2, "R8 set wins");
    check("R9 irq after set", {31'b0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R11 pending reads", 32'(exp_q.size()), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule